// File: doc/BRIEF.md
# Masked Port Interrupt-on-Change Detector

This block watches an 8-bit input port and raises an interrupt when any of its four upper pins changes level. A control register holds one enable per monitored pin in its upper nibble. The lower nibble has no storage and always reads as zero. Each incoming pin passes through a two-stage synchronizer. A change is seen as a mismatch between the synchronized level and a reference copy. That reference is reloaded whenever software reads the port.

Every enabled pin that mismatches sets one shared, sticky change flag. Software clears the flag with a strobe. The flag becomes an interrupt request only while a global enable input is high. A priority input sends that request to either the high-priority output or the low-priority output. The normal service sequence is: read the port to reload the reference, then clear the flag.

Top module: `nibble_change_irq`

## Requirements
- R1: After reset the control readback is 0x00, the change flag is 0, both interrupt outputs are 0, and the reference is all zeros.
- R2: A control write stores bits 7..4 as per-pin enables, where bit 4+i enables port pin 4+i and 1 means enabled. The stored value is visible on the readback from the cycle after the write.
- R3: Control readback bits 3..0 are always 0, whatever value was written to them.
- R4: A level change on an enabled upper pin is not visible on the flag after two rising clock edges. It is visible after the third edge: two synchronizer stages, then the flag register.
- R5: A level change on port bits 3..0 never sets the flag.
- R6: A level change on an upper pin whose enable bit is 0 never sets the flag.
- R7: The flag stays set until a clear strobe arrives. A clear with no pending mismatch drops the flag at the next edge.
- R8: If a mismatch is still pending when the clear strobe arrives, the flag stays set. A port-read strobe loads the reference from the synchronized level, which ends the mismatch.
- R9: A request is raised only when the flag and the global enable are both 1. It appears on irqHigh when prioHigh is 1 and on irqLow when prioHigh is 0, and never on both outputs at once.
- R10: portRdData shows the synchronized 8-bit port level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portIn | input | 8 | Asynchronous port pins |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control write data |
| ctrlRdData | output | 8 | Control readback; bits 3..0 read as 0 |
| portRdStrobe | input | 1 | Port read; reloads the reference |
| portRdData | output | 8 | Synchronized port level |
| flagClr | input | 1 | Clear strobe for the change flag |
| globalEn | input | 1 | Global interrupt gate |
| prioHigh | input | 1 | 1 selects the high-priority output |
| changeFlag | output | 1 | Shared sticky change flag |
| irqHigh | output | 1 | High-priority request |
| irqLow | output | 1 | Low-priority request |

## Verification
The hardest case to reach is a clear strobe that arrives while a mismatch is still pending. The clear must then lose, and the flag must drop only after a port read has reloaded the reference. The bench sets the flag, issues a clear without reading the port first, and checks that the flag is still set. It then reads the port, clears again, and checks that the flag has dropped. It also sweeps all 16 enable masks against toggles on each of the 8 pins, so that disabled pins and low pins are shown to leave the flag untouched while other pins stay steady.

// File: rtl/nci_pkg.sv
package nci_pkg;
  typedef struct packed {
    logic ctrlWr;
    logic refLoad;
    logic flagSet;
    logic flagClr;
  } nciStrobes_t;
endpackage

// File: rtl/nci_datapath.sv
module nci_datapath
  import nci_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int MON_LSB = 4,
  parameter int SYNC_STAGES = 2,
  localparam int MON_W = PORT_W - MON_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] portIn,
  input  logic [MON_W-1:0]  enWrData,
  input  nciStrobes_t       strb,
  output logic [PORT_W-1:0] syncLevel,
  output logic [MON_W-1:0]  pinEn,
  output logic              mismatchAny,
  output logic              flagQ
);
  logic [PORT_W-1:0] syncStage [SYNC_STAGES];
  logic [MON_W-1:0]  refQ;
  logic [MON_W-1:0]  mismatchVec;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncStage[0] <= '0;
          else       syncStage[0] <= portIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncStage[s] <= '0;
          else       syncStage[s] <= syncStage[s-1];
        end
      end
    end
  endgenerate

  assign syncLevel = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinEn <= '0;
      refQ  <= '0;
      flagQ <= 1'b0;
    end else begin
      if (strb.ctrlWr)  pinEn <= enWrData;
      if (strb.refLoad) refQ  <= syncLevel[PORT_W-1:MON_LSB];
      if (strb.flagSet)      flagQ <= 1'b1;
      else if (strb.flagClr) flagQ <= 1'b0;
    end
  end

  assign mismatchVec = (syncLevel[PORT_W-1:MON_LSB] ^ refQ) & pinEn;
  assign mismatchAny = |mismatchVec;

  // R4
  flag_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    mismatchAny |=> flagQ);
  // R7
  flag_no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && !mismatchAny) |=> !flagQ);
  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr |=> pinEn == $past(enWrData));
endmodule

// File: rtl/nci_control.sv
module nci_control
  import nci_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic        portRdStrobe,
  input  logic        flagClr,
  input  logic        mismatchAny,
  input  logic        flagQ,
  input  logic        globalEn,
  input  logic        prioHigh,
  output nciStrobes_t strb,
  output logic        irqHigh,
  output logic        irqLow
);
  logic reqActive;

  always_comb begin
    strb.ctrlWr  = ctrlWrEn;
    strb.refLoad = portRdStrobe;
    strb.flagSet = mismatchAny;
    strb.flagClr = flagClr & ~mismatchAny;
  end

  assign reqActive = flagQ & globalEn;
  assign irqHigh   = reqActive & prioHigh;
  assign irqLow    = reqActive & ~prioHigh;

  // R9
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqHigh, irqLow}));
  // R9
  irq_needs_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqHigh || irqLow) |-> (flagQ && globalEn));
  // R7
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !mismatchAny) |=> !flagQ);
  // R8
  clear_loses_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && mismatchAny) |=> flagQ);
endmodule

// File: rtl/nibble_change_irq.sv
module nibble_change_irq
  import nci_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int MON_LSB = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] portIn,
  input  logic              ctrlWrEn,
  input  logic [PORT_W-1:0] ctrlWrData,
  output logic [PORT_W-1:0] ctrlRdData,
  input  logic              portRdStrobe,
  output logic [PORT_W-1:0] portRdData,
  input  logic              flagClr,
  input  logic              globalEn,
  input  logic              prioHigh,
  output logic              changeFlag,
  output logic              irqHigh,
  output logic              irqLow
);
  localparam int MON_W = PORT_W - MON_LSB;

  nciStrobes_t      strb;
  logic [MON_W-1:0] pinEn;
  logic             mismatchAny;
  logic             flagQ;

  nci_datapath #(.PORT_W(PORT_W), .MON_LSB(MON_LSB), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .portIn(portIn),
    .enWrData(ctrlWrData[PORT_W-1:MON_LSB]), .strb(strb),
    .syncLevel(portRdData), .pinEn(pinEn),
    .mismatchAny(mismatchAny), .flagQ(flagQ)
  );

  nci_control u_ctl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .portRdStrobe(portRdStrobe),
    .flagClr(flagClr), .mismatchAny(mismatchAny), .flagQ(flagQ),
    .globalEn(globalEn), .prioHigh(prioHigh), .strb(strb),
    .irqHigh(irqHigh), .irqLow(irqLow)
  );

  assign ctrlRdData = {pinEn, {MON_LSB{1'b0}}};
  assign changeFlag = flagQ;
endmodule

// File: tb/nibble_change_irq_tb.sv
module nibble_change_irq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] portIn = '0;
  logic ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic [7:0] ctrlRdData;
  logic portRdStrobe = 1'b0;
  logic [7:0] portRdData;
  logic flagClr = 1'b0;
  logic globalEn = 1'b0;
  logic prioHigh = 1'b0;
  logic changeFlag, irqHigh, irqLow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nibble_change_irq u_dut (
    .clk(clk), .rstN(rstN), .portIn(portIn), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .portRdStrobe(portRdStrobe), .portRdData(portRdData),
    .flagClr(flagClr), .globalEn(globalEn), .prioHigh(prioHigh),
    .changeFlag(changeFlag), .irqHigh(irqHigh), .irqLow(irqLow)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    ctrlWrData = d; ctrlWrEn = 1'b1; cyc(1); ctrlWrEn = 1'b0;
  endtask

  task automatic service();
    portRdStrobe = 1'b1; cyc(1); portRdStrobe = 1'b0;
    flagClr = 1'b1; cyc(1); flagClr = 1'b0;
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    chk(ctrlRdData, 8'h00, "R1 ctrl reset");
    chk({7'd0, changeFlag}, 8'h00, "R1 flag reset");
    chk({6'd0, irqHigh, irqLow}, 8'h00, "R1 irq reset");

    // R4 latency: enable pin 6, toggle it
    wrCtrl(8'h4F);
    chk(ctrlRdData, 8'h40, "R2 R3 readback");
    portIn[6] = 1'b1;
    cyc(1);
    chk({7'd0, changeFlag}, 8'h00, "R4 edge1");
    cyc(1);
    chk({7'd0, changeFlag}, 8'h00, "R4 edge2");
    chk(portRdData, 8'h40, "R10 sync level");
    cyc(1);
    chk({7'd0, changeFlag}, 8'h01, "R4 edge3");

    // R9 routing
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < 2; p++) begin
        globalEn = g[0]; prioHigh = p[0];
        #1;
        chk({6'd0, irqHigh, irqLow}, {6'd0, g[0] & p[0], g[0] & ~p[0]}, "R9 routing");
      end
    end
    globalEn = 1'b0;

    // R8: clear while mismatch pending loses
    flagClr = 1'b1; cyc(1); flagClr = 1'b0;
    chk({7'd0, changeFlag}, 8'h01, "R8 clear loses");
    cyc(2);
    chk({7'd0, changeFlag}, 8'h01, "R7 sticky");
    portRdStrobe = 1'b1; cyc(1); portRdStrobe = 1'b0;
    flagClr = 1'b1; cyc(1); flagClr = 1'b0;
    chk({7'd0, changeFlag}, 8'h00, "R8 R7 cleared after read");

    // Sweep masks x pins: R2 R3 R5 R6 R4
    for (int m = 0; m < 16; m++) begin
      wrCtrl({m[3:0], ~m[3:0]});
      chk(ctrlRdData, {m[3:0], 4'h0}, "R2 R3 sweep readback");
      for (int b = 0; b < 8; b++) begin
        automatic logic expF = (b >= 4) && m[b-4];
        portIn[b] = ~portIn[b];
        cyc(4);
        chk({7'd0, changeFlag}, {7'd0, expF},
            b < 4 ? "R5 low pin" : (expF ? "R4 enabled pin" : "R6 disabled pin"));
        chk(portRdData, portIn, "R10 level");
        cyc(1);
        service();
        if (!expF) begin
          // a disabled pin now matches after the read; reference realigned
        end
        chk({7'd0, changeFlag}, 8'h00, "R7 serviced");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule